// File: doc/BRIEF.md
# Wormhole Virtual-Channel Input Unit

This block is one input port of a five-port mesh router whose outputs face North, East, South, West and Local. Flits arrive on a shared link, each tagged with a virtual-channel (VC) number, and wait in a small FIFO for that VC. A packet is a head flit, one or more body flits and a tail flit. Only the head carries the destination. When a head reaches the front of its FIFO, the block works out the output port by dimension order: the row is resolved first, then the column. It then claims a free downstream VC on that port. Both results are held as per-packet state until the tail has left.

Each VC holds a small state machine. Its states are `VS_IDLE`, `VS_ROUTED` and `VS_ACTIVE`. It moves from `VS_IDLE` to `VS_ROUTED` on a head at the FIFO front, taking the computed port. It moves from `VS_ROUTED` to `VS_ACTIVE` once an idle downstream VC exists on that port, taking the lowest such VC. It returns from `VS_ACTIVE` to `VS_IDLE` when the tail is popped. In `VS_ACTIVE`, the VC asks an external switch allocator for its output port and downstream VC whenever its FIFO holds a flit and the chosen downstream VC has room. A grant pops the front flit, and one cycle later a credit naming the VC goes back upstream.

A blocked packet stalls only its own VC. Packets in other VCs keep moving through the same input.

Top module: `vc_input_unit`

## Requirements
- R1: The flit type is held in the top two bits of a flit: 01 marks a head, 10 a body and 11 a tail. A head carries the destination row in bits [3:2] and the destination column in bits [1:0].
- R2: The output port is coded North=0, East=1, South=2, West=3 and Local=4. A destination row below the local row gives North, and a row above it gives South. With equal rows, a larger column gives East and a smaller column gives West. A destination equal to the local address gives Local.
- R3: The route is computed only for a head at the front of a VC in `VS_IDLE`, one cycle after the head is written. Body and tail flits present the same `req_port` as their head.
- R4: In `VS_ROUTED`, the VC waits until a bit of `ovc_idle` is set for its port, at index port*NUM_VC+vc. It then takes the lowest such VC and keeps it in `req_ovc` for the whole packet, even if `ovc_idle` changes.
- R5: A VC raises `req_valid` only in `VS_ACTIVE`, with a non-empty FIFO, and while its `ovc_space` bit (same indexing) is set. Clearing that bit withdraws the request.
- R6: A flit is popped only when `grant` and `req_valid` of the same VC are both high. A grant on a VC that is not requesting removes nothing.
- R7: Each pop produces `credit_valid` for exactly one cycle, starting the cycle after the pop, with `credit_vc` equal to the popped VC. There is no credit without a pop.
- R8: Popping a tail returns its VC to `VS_IDLE`, and its request drops in the next cycle.
- R9: A head that cannot advance holds the body flits behind it in the same VC. Another VC on the same input still routes, requests and drains.
- R10: A VC FIFO holds DEPTH flits, and filling it to exactly DEPTH raises no error. A write into a full FIFO is dropped and raises `overflow_err` for one cycle.
- R11: After reset, every VC is idle, with no request, no credit and no error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| my_row | input | COORD_W | Row coordinate of this router |
| my_col | input | COORD_W | Column coordinate of this router |
| in_valid | input | 1 | Incoming flit strobe |
| in_vc | input | VC_W | VC number of the incoming flit |
| in_flit | input | FLIT_W | Incoming flit |
| ovc_idle | input | 5*NUM_VC | Downstream VC free to claim, per port and VC |
| ovc_space | input | 5*NUM_VC | Downstream VC has a free slot, per port and VC |
| grant | input | NUM_VC | Switch allocator grant, at most one bit high |
| req_valid | output | NUM_VC | Request per VC |
| req_port | output | 3*NUM_VC | Requested output port per VC |
| req_ovc | output | VC_W*NUM_VC | Downstream VC per VC |
| vc_flit | output | FLIT_W*NUM_VC | Front flit of each VC, toward the crossbar |
| credit_valid | output | 1 | Credit pulse to upstream |
| credit_vc | output | VC_W | VC the credit belongs to |
| overflow_err | output | 1 | Write into a full VC FIFO |

## Verification
A head written at clock edge E0 gets its route at E1 and its downstream VC at E2. Its request is therefore first visible after E2, provided an idle downstream VC exists. A grant seen at the next edge pops the flit, and the credit is visible right after that same edge for one cycle. The request's withdrawal after a tail pop is also visible right after that edge. The bench drives inputs and samples outputs on the falling edge. It counts whole cycles from each write or grant to these edges, so every check lands in the first cycle a result is due. Stalls are checked by holding a condition several cycles and confirming that no request or credit appears.

// File: rtl/vcin_pkg.sv
package vcin_pkg;
    localparam int NPORT  = 5;
    localparam int PORT_W = 3;

    typedef enum logic [1:0] {
        FT_NONE = 2'b00,
        FT_HEAD = 2'b01,
        FT_BODY = 2'b10,
        FT_TAIL = 2'b11
    } flit_kind_e;

    typedef enum logic [2:0] {
        P_NORTH = 3'd0,
        P_EAST  = 3'd1,
        P_SOUTH = 3'd2,
        P_WEST  = 3'd3,
        P_LOCAL = 3'd4
    } port_e;

    typedef enum logic [1:0] {
        VS_IDLE   = 2'b00,
        VS_ROUTED = 2'b01,
        VS_ACTIVE = 2'b10
    } vc_state_e;
endpackage

// File: rtl/vcin_fifo.sv
module vcin_fifo #(
    parameter int WIDTH = 16,
    parameter int DEPTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [WIDTH-1:0] wr_data,
    input  logic             rd_en,
    output logic [WIDTH-1:0] rd_data,
    output logic             empty,
    output logic             full
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [PTR_W-1:0] wp, rp;
    logic [CNT_W-1:0] cnt;
    logic             do_wr, do_rd;

    assign empty   = (cnt == '0);
    assign full    = (cnt == CNT_W'(DEPTH));
    assign do_wr   = wr_en && !full;
    assign do_rd   = rd_en && !empty;
    assign rd_data = mem[rp];

    always_ff @(posedge clk) begin
        if (do_wr) mem[wp] <= wr_data;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            if (do_wr) wp <= (wp == PTR_W'(DEPTH - 1)) ? '0 : wp + 1'b1;
            if (do_rd) rp <= (rp == PTR_W'(DEPTH - 1)) ? '0 : rp + 1'b1;
            unique case ({do_wr, do_rd})
                2'b10:   cnt <= cnt + 1'b1;
                2'b01:   cnt <= cnt - 1'b1;
                default: cnt <= cnt;
            endcase
        end
    end

    // R10: occupancy never exceeds the depth
    p_count_bound_r10: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CNT_W'(DEPTH));
    // R10: a write into a full FIFO with no read leaves it full (flit dropped)
    p_drop_when_full_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && full && !rd_en) |=> full);
    // R6: reads are only requested when data exists
    p_rd_nonempty_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |-> !empty);
endmodule

// File: rtl/vcin_route.sv
module vcin_route
    import vcin_pkg::*;
#(
    parameter int COORD_W = 2
) (
    input  logic [COORD_W-1:0] my_row,
    input  logic [COORD_W-1:0] my_col,
    input  logic [COORD_W-1:0] dst_row,
    input  logic [COORD_W-1:0] dst_col,
    output logic [PORT_W-1:0]  out_port
);
    // Dimension order: rows first, then columns
    always_comb begin
        if (dst_row < my_row)      out_port = P_NORTH;
        else if (dst_row > my_row) out_port = P_SOUTH;
        else if (dst_col > my_col) out_port = P_EAST;
        else if (dst_col < my_col) out_port = P_WEST;
        else                       out_port = P_LOCAL;
    end
endmodule

// File: rtl/vcin_vc_ctrl.sv
module vcin_vc_ctrl
    import vcin_pkg::*;
#(
    parameter int COORD_W = 2,
    parameter int NUM_VC  = 2,
    parameter int VC_W    = 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [COORD_W-1:0]      my_row,
    input  logic [COORD_W-1:0]      my_col,
    input  logic [1:0]              front_kind_raw,
    input  logic [COORD_W-1:0]      front_row,
    input  logic [COORD_W-1:0]      front_col,
    input  logic                    fifo_empty,
    input  logic [NPORT*NUM_VC-1:0] ovc_idle,
    input  logic [NPORT*NUM_VC-1:0] ovc_space,
    input  logic                    grant,
    output logic                    req_valid,
    output logic [PORT_W-1:0]       req_port,
    output logic [VC_W-1:0]         req_ovc,
    output logic                    pop
);
    vc_state_e        state_q, state_d;
    logic [PORT_W-1:0] port_q, port_d, rc_port;
    logic [VC_W-1:0]   ovc_q, ovc_d, pick_vc;
    logic              pick_ok, space_ok, tail_pop;
    flit_kind_e        front_kind;
    logic [NUM_VC-1:0] idle_by_port  [NPORT];
    logic [NUM_VC-1:0] space_by_port [NPORT];

    assign front_kind = flit_kind_e'(front_kind_raw);

    for (genvar p = 0; p < NPORT; p++) begin : g_split
        assign idle_by_port[p]  = ovc_idle[p*NUM_VC +: NUM_VC];
        assign space_by_port[p] = ovc_space[p*NUM_VC +: NUM_VC];
    end

    vcin_route #(.COORD_W(COORD_W)) i_route (
        .my_row  (my_row),
        .my_col  (my_col),
        .dst_row (front_row),
        .dst_col (front_col),
        .out_port(rc_port)
    );

    // Lowest-numbered idle downstream VC on the latched port
    always_comb begin
        pick_ok = 1'b0;
        pick_vc = '0;
        for (int v = NUM_VC - 1; v >= 0; v--) begin
            if (idle_by_port[port_q][v]) begin
                pick_ok = 1'b1;
                pick_vc = VC_W'(v);
            end
        end
    end

    assign space_ok = space_by_port[port_q][ovc_q];

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= VS_IDLE;
            port_q  <= P_LOCAL;
            ovc_q   <= '0;
        end else begin
            state_q <= state_d;
            port_q  <= port_d;
            ovc_q   <= ovc_d;
        end
    end

    // Next state
    always_comb begin
        state_d = state_q;
        port_d  = port_q;
        ovc_d   = ovc_q;
        unique case (state_q)
            VS_IDLE: begin
                if (!fifo_empty && front_kind == FT_HEAD) begin
                    port_d  = rc_port;
                    state_d = VS_ROUTED;
                end
            end
            VS_ROUTED: begin
                if (pick_ok) begin
                    ovc_d   = pick_vc;
                    state_d = VS_ACTIVE;
                end
            end
            VS_ACTIVE: begin
                if (tail_pop) state_d = VS_IDLE;
            end
            default: state_d = VS_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        req_valid = (state_q == VS_ACTIVE) && !fifo_empty && space_ok;
        pop       = req_valid && grant;
        tail_pop  = pop && (front_kind == FT_TAIL);
        req_port  = port_q;
        req_ovc   = ovc_q;
    end

    // R3: route and downstream VC hold for the life of a packet
    p_hold_route_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == VS_ACTIVE && !tail_pop) |=>
            (state_q == VS_ACTIVE && $stable(port_q) && $stable(ovc_q)));
    // R3: leaving idle only happens for a head at the front
    p_route_on_head_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == VS_IDLE && !(front_kind == FT_HEAD && !fifo_empty)) |=>
            state_q == VS_IDLE);
    // R8: a tail pop releases the VC
    p_tail_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
        tail_pop |=> (state_q == VS_IDLE && !req_valid));
    // R4: entering active requires an idle downstream VC on the port
    p_claim_needs_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == VS_ROUTED && !pick_ok) |=> state_q == VS_ROUTED);
endmodule

// File: rtl/vc_input_unit.sv
module vc_input_unit
    import vcin_pkg::*;
#(
    parameter int NUM_VC  = 2,
    parameter int DEPTH   = 4,
    parameter int COORD_W = 2,
    parameter int FLIT_W  = 16,
    localparam int VC_W   = (NUM_VC > 1) ? $clog2(NUM_VC) : 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [COORD_W-1:0]       my_row,
    input  logic [COORD_W-1:0]       my_col,
    input  logic                     in_valid,
    input  logic [VC_W-1:0]          in_vc,
    input  logic [FLIT_W-1:0]        in_flit,
    input  logic [5*NUM_VC-1:0]      ovc_idle,
    input  logic [5*NUM_VC-1:0]      ovc_space,
    input  logic [NUM_VC-1:0]        grant,
    output logic [NUM_VC-1:0]        req_valid,
    output logic [3*NUM_VC-1:0]      req_port,
    output logic [VC_W*NUM_VC-1:0]   req_ovc,
    output logic [FLIT_W*NUM_VC-1:0] vc_flit,
    output logic                     credit_valid,
    output logic [VC_W-1:0]          credit_vc,
    output logic                     overflow_err
);
    logic [NUM_VC-1:0] pop_vec, empty_vec, full_vec;
    logic              pop_any;
    logic [VC_W-1:0]   pop_idx;

    for (genvar g = 0; g < NUM_VC; g++) begin : g_vc
        logic [FLIT_W-1:0] front;
        logic              wr;

        assign wr = in_valid && (in_vc == VC_W'(g));
        assign vc_flit[g*FLIT_W +: FLIT_W] = front;

        vcin_fifo #(.WIDTH(FLIT_W), .DEPTH(DEPTH)) i_fifo (
            .clk    (clk),
            .rst_n  (rst_n),
            .wr_en  (wr),
            .wr_data(in_flit),
            .rd_en  (pop_vec[g]),
            .rd_data(front),
            .empty  (empty_vec[g]),
            .full   (full_vec[g])
        );

        vcin_vc_ctrl #(.COORD_W(COORD_W), .NUM_VC(NUM_VC), .VC_W(VC_W)) i_ctrl (
            .clk           (clk),
            .rst_n         (rst_n),
            .my_row        (my_row),
            .my_col        (my_col),
            .front_kind_raw(front[FLIT_W-1 -: 2]),
            .front_row     (front[2*COORD_W-1 -: COORD_W]),
            .front_col     (front[COORD_W-1:0]),
            .fifo_empty    (empty_vec[g]),
            .ovc_idle      (ovc_idle),
            .ovc_space     (ovc_space),
            .grant         (grant[g]),
            .req_valid     (req_valid[g]),
            .req_port      (req_port[g*PORT_W +: PORT_W]),
            .req_ovc       (req_ovc[g*VC_W +: VC_W]),
            .pop           (pop_vec[g])
        );
    end

    always_comb begin
        pop_any = |pop_vec;
        pop_idx = '0;
        for (int v = 0; v < NUM_VC; v++) begin
            if (pop_vec[v]) pop_idx = VC_W'(v);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            credit_valid <= 1'b0;
            credit_vc    <= '0;
            overflow_err <= 1'b0;
        end else begin
            credit_valid <= pop_any;
            credit_vc    <= pop_idx;
            overflow_err <= in_valid && full_vec[in_vc];
        end
    end

    // R7: an accepted grant yields a credit in the next cycle
    p_credit_after_pop_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (|(grant & req_valid)) |=> credit_valid);
    // R7: no credit without an accepted grant
    p_no_spurious_credit_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(|(grant & req_valid)) |=> !credit_valid);
    // R6: at most one VC leaves per cycle
    p_single_pop_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(pop_vec));
endmodule

// File: tb/test_vc_input_unit.sv
`timescale 1ns/1ps
module test_vc_input_unit;
    localparam int NV = 2;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [1:0]  my_row, my_col;
    logic        in_valid;
    logic [0:0]  in_vc;
    logic [15:0] in_flit;
    logic [9:0]  ovc_idle, ovc_space;
    logic [1:0]  grant;
    logic [1:0]  req_valid;
    logic [5:0]  req_port;
    logic [1:0]  req_ovc;
    logic [31:0] vc_flit;
    logic        credit_valid;
    logic [0:0]  credit_vc;
    logic        overflow_err;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    vc_input_unit #(.NUM_VC(NV), .DEPTH(4), .COORD_W(2), .FLIT_W(16)) i_vc_input_unit (
        .clk(clk), .rst_n(rst_n), .my_row(my_row), .my_col(my_col),
        .in_valid(in_valid), .in_vc(in_vc), .in_flit(in_flit),
        .ovc_idle(ovc_idle), .ovc_space(ovc_space), .grant(grant),
        .req_valid(req_valid), .req_port(req_port), .req_ovc(req_ovc),
        .vc_flit(vc_flit), .credit_valid(credit_valid), .credit_vc(credit_vc),
        .overflow_err(overflow_err)
    );

    // {my_row, my_col, dst_row, dst_col, expected port}
    localparam logic [10:0] ROUTES [8] = '{
        {2'd1, 2'd1, 2'd0, 2'd3, 3'd0},
        {2'd1, 2'd1, 2'd3, 2'd0, 3'd2},
        {2'd1, 2'd1, 2'd1, 2'd3, 3'd1},
        {2'd1, 2'd1, 2'd1, 2'd0, 3'd3},
        {2'd1, 2'd1, 2'd1, 2'd1, 3'd4},
        {2'd0, 2'd0, 2'd0, 2'd0, 3'd4},
        {2'd3, 2'd3, 2'd0, 2'd0, 3'd0},
        {2'd0, 2'd2, 2'd3, 2'd2, 3'd2}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic send(input logic v, input logic [15:0] f);
        in_valid = 1'b1;
        in_vc    = v;
        in_flit  = f;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    // R1 encodings: head 01, body 10, tail 11; dest row [3:2], col [1:0]
    function automatic logic [15:0] head(input logic [1:0] r, input logic [1:0] c);
        return {2'b01, 10'h0A5, r, c};
    endfunction
    function automatic logic [15:0] body(input logic [7:0] d);
        return {2'b10, 6'h00, d};
    endfunction
    function automatic logic [15:0] tail(input logic [7:0] d);
        return {2'b11, 6'h00, d};
    endfunction

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog (all) actual timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; my_row = 2'd1; my_col = 2'd1;
        in_valid = 1'b0; in_vc = '0; in_flit = '0;
        ovc_idle = '1; ovc_space = '1; grant = '0;
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        chk("R11 req_valid after reset", 32'(req_valid), 32'd0);
        chk("R11 credit after reset", 32'(credit_valid), 32'd0);
        chk("R11 error after reset", 32'(overflow_err), 32'd0);

        // Table walk: R1, R2, R3, R7, R8
        for (int i = 0; i < 8; i++) begin
            logic [2:0] ep;
            my_row = ROUTES[i][10:9];
            my_col = ROUTES[i][8:7];
            ep     = ROUTES[i][2:0];
            send(1'b0, head(ROUTES[i][6:5], ROUTES[i][4:3]));
            send(1'b0, body(8'(i)));
            send(1'b0, tail(8'(i)));
            chk($sformatf("R3 req due two cycles after head, vec %0d", i), 32'(req_valid[0]), 32'd1);
            chk($sformatf("R2 route vec %0d", i), 32'(req_port[2:0]), 32'(ep));
            chk($sformatf("R1 head at front vec %0d", i), 32'(vc_flit[15:14]), 32'd1);
            grant = 2'b01;
            for (int k = 0; k < 3; k++) begin
                tick();
                chk($sformatf("R7 credit pulse vec %0d flit %0d", i, k), 32'({credit_valid, credit_vc}), 32'b10);
                if (k < 2)
                    chk($sformatf("R3 inherited port vec %0d flit %0d", i, k), 32'(req_port[2:0]), 32'(ep));
                else
                    chk($sformatf("R8 release after tail vec %0d", i), 32'(req_valid[0]), 32'd0);
            end
            grant = 2'b00;
            tick();
            chk($sformatf("R7 single-cycle credit vec %0d", i), 32'(credit_valid), 32'd0);
        end

        // R4: wait for an idle downstream VC on North, take lowest, keep it
        my_row = 2'd2; my_col = 2'd2;
        ovc_idle = 10'h3FC;                 // North bits 0,1 cleared
        send(1'b0, head(2'd0, 2'd2));
        send(1'b0, body(8'h11));
        repeat (3) tick();
        chk("R4 waits with no idle downstream VC", 32'(req_valid[0]), 32'd0);
        ovc_idle = 10'h002;                 // only North VC1 idle
        tick();
        chk("R4 request after claim", 32'(req_valid[0]), 32'd1);
        chk("R4 lowest idle VC chosen", 32'(req_ovc[0]), 32'd1);
        ovc_idle = 10'h000;
        grant = 2'b01;
        tick();
        grant = 2'b00;
        chk("R4 downstream VC kept", 32'(req_ovc[0]), 32'd1);
        // R5 / R6: space removed, grant without request
        ovc_space = 10'h3FD;                // North VC1 full
        tick();
        chk("R5 no request without space", 32'(req_valid[0]), 32'd0);
        grant = 2'b01;
        tick();
        grant = 2'b00;
        chk("R6 grant without request gives no credit", 32'(credit_valid), 32'd0);
        ovc_space = '1;
        tick();
        chk("R6 body still at front", 32'(vc_flit[15:14]), 32'd2);
        chk("R5 request returns with space", 32'(req_valid[0]), 32'd1);
        send(1'b0, tail(8'h12));
        grant = 2'b01;
        tick();
        tick();
        grant = 2'b00;
        chk("R8 VC idle after tail", 32'(req_valid[0]), 32'd0);
        ovc_idle = '1;

        // R9: VC0 blocked on East, VC1 to West proceeds
        my_row = 2'd1; my_col = 2'd1;
        ovc_space = 10'h3FB;                // East VC0 no space
        send(1'b0, head(2'd1, 2'd3));
        send(1'b0, body(8'h21));
        send(1'b1, head(2'd1, 2'd0));
        send(1'b1, tail(8'h31));
        tick();
        chk("R9 other VC requests", 32'(req_valid), 32'b10);
        chk("R9 other VC port West", 32'(req_port[5:3]), 32'd3);
        grant = 2'b10;
        tick();
        chk("R9 credit for VC1", 32'({credit_valid, credit_vc}), 32'b11);
        tick();
        grant = 2'b00;
        chk("R9 VC1 drained, VC0 still held", 32'(req_valid), 32'b00);
        ovc_space = '1;
        tick();
        chk("R9 VC0 resumes toward East", 32'({req_valid[0], req_port[2:0]}), 32'b1001);
        chk("R9 VC0 downstream VC", 32'(req_ovc[0]), 32'd0);
        send(1'b0, tail(8'h22));
        grant = 2'b01;
        repeat (3) tick();
        grant = 2'b00;
        chk("R8 VC0 released", 32'(req_valid[0]), 32'd0);

        // R10: fill VC1 to exactly DEPTH while it cannot claim a VC
        ovc_idle = '0;
        send(1'b1, head(2'd1, 2'd1));
        chk("R10 no error at 1", 32'(overflow_err), 32'd0);
        send(1'b1, body(8'h41));
        chk("R10 no error at 2", 32'(overflow_err), 32'd0);
        send(1'b1, body(8'h42));
        chk("R10 no error at 3", 32'(overflow_err), 32'd0);
        send(1'b1, tail(8'h43));
        chk("R10 no error at depth", 32'(overflow_err), 32'd0);
        chk("R10 held while routed", 32'(req_valid), 32'd0);
        ovc_idle = '1;
        tick();
        chk("R2 local route for own address", 32'(req_port[5:3]), 32'd4);
        grant = 2'b10;
        begin
            int credits = 0;
            for (int k = 0; k < 4; k++) begin
                tick();
                if (credit_valid && credit_vc == 1'b1) credits++;
            end
            chk("R10 four stored flits delivered", 32'(credits), 32'd4);
        end
        grant = 2'b00;
        chk("R8 VC1 idle after drain", 32'(req_valid), 32'd0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule